// File: doc/BRIEF.md
# Parallel NOR Flash Erase Command Sequencer

This block sits on the host side of a parallel NOR flash and produces the write-bus traffic for three standard software command sequences: a 64-KByte block erase, a 4-KByte sector erase, and entry into the common flash query mode. The host presents an operation code, a target byte address and a variant select in a single clock. While the sequencer is idle it accepts the request and then drives the address, data, chip-enable and write-enable pins through every write cycle of that sequence. It pulses `done` when the last write cycle has finished.

The variant select picks between two families of parts. The wide-address family uses 15-bit unlock addresses, and a sixth-cycle opcode of 50h means block erase. The narrow-address family uses 11-bit unlock addresses, and its sixth-cycle opcode mapping is the reverse, so 30h means block erase. Erase blocks are uniform in size, including the boot block, so an erase address is found by masking the target address. Polling for erase completion, programming and read cycles are handled elsewhere.

Each write cycle has a fixed shape. Address and data settle for `SETUP_CLKS` clocks, write-enable is low for `PULSE_CLKS` clocks, and one further clock holds address and data after write-enable rises.

Top module: `nor_cmd_sequencer`

## Requirements
- R1: After reset, flash_ce_n and flash_we_n are 1, busy, done and req_err are 0, and flash_addr and flash_data are 0. flash_addr and flash_data stay 0 whenever flash_ce_n is 1.
- R2: An erase request (req_op 0 = block, 1 = sector) issues six write cycles. Their data bytes are AAh, 55h, 80h, AAh, 55h, then the erase opcode, placed in the low 8 bits of flash_data with the upper bits 0. Their addresses are first unlock, second unlock, first, first, second, then the erase address.
- R3: With req_narrow = 0, the first and second unlock addresses are 5555h and 2AAAh, and the sixth-cycle opcode is 50h for block erase and 30h for sector erase.
- R4: With req_narrow = 1, the unlock addresses are 555h and 2AAh, and the sixth-cycle opcode is 30h for block erase and 50h for sector erase.
- R5: The sixth-cycle address is the target with its low 16 bits cleared for a block erase, and the target with its low 12 bits cleared for a sector erase.
- R6: A query-entry request (req_op 2) issues three write cycles: AAh to the first unlock address, 55h to the second, and 98h to the first.
- R7: Every write cycle keeps flash_ce_n low. It spends SETUP_CLKS clocks with flash_we_n high, then PULSE_CLKS clocks with flash_we_n low, then one hold clock with flash_we_n high. flash_addr and flash_data do not change within a write cycle. Consecutive write cycles follow with no gap.
- R8: busy is 1 from the clock after acceptance through the hold clock of the last write cycle. done is 1 for exactly one clock, the one right after that hold clock, and in that clock busy is 0 and flash_ce_n is 1.
- R9: A request that arrives while busy is ignored. req_err is 1 for the following clock, and the running sequence continues unchanged.
- R10: A request with req_op 3 is rejected. req_err is 1 for the following clock, and no bus activity follows.
- R11: The operation, variant and target are captured at acceptance. Changing req_narrow or req_addr during a sequence has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request strobe, one clock |
| req_op | input | 2 | 0 block erase, 1 sector erase, 2 query entry, 3 invalid |
| req_narrow | input | 1 | 1 selects the narrow (11-bit) unlock format and its opcode mapping |
| req_addr | input | ADDR_W | Target byte address for an erase |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_data | output | DATA_W | Flash write data bus |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock pulse after the last write cycle |
| req_err | output | 1 | One-clock pulse when a request is rejected |

## Verification
All three operations are swept across both variants and across target addresses whose low bits are zero, all ones, or mixed. This separates clearing 12 bits from clearing 16 bits, and wide unlock addresses from narrow ones. Because the opcode is checked per variant and per erase kind, it shows whether the 30h/50h mapping is swapped. In every cycle the expected pin values are derived from the position within the write cycle, so an error in the setup, pulse or hold count shows up in the first affected clock. Further runs change the variant and address inputs mid-sequence, inject a request while busy, and issue the invalid code. These show that captured state is isolated from the live inputs and that rejected requests leave the bus untouched.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    OP_BLOCK  = 2'd0,
    OP_SECTOR = 2'd1,
    OP_QUERY  = 2'd2,
    OP_BAD    = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  typedef struct packed {
    op_e  op;
    logic narrow;
  } cmd_ctx_t;

  localparam logic [7:0] BYTE_KEY_A  = 8'hAA;
  localparam logic [7:0] BYTE_KEY_B  = 8'h55;
  localparam logic [7:0] BYTE_ARM    = 8'h80;
  localparam logic [7:0] BYTE_QUERY  = 8'h98;
  localparam logic [7:0] BYTE_OPC_LO = 8'h30;
  localparam logic [7:0] BYTE_OPC_HI = 8'h50;

  localparam logic [15:0] WIDE_KEY_ADDR_A   = 16'h5555;
  localparam logic [15:0] WIDE_KEY_ADDR_B   = 16'h2AAA;
  localparam logic [15:0] NARROW_KEY_ADDR_A = 16'h0555;
  localparam logic [15:0] NARROW_KEY_ADDR_B = 16'h02AA;

  localparam int BLOCK_LSB  = 16;
  localparam int SECTOR_LSB = 12;

  function automatic logic [2:0] seq_len(op_e op);
    return (op == OP_QUERY) ? 3'd3 : 3'd6;
  endfunction

endpackage

// File: rtl/nor_rst_sync.sv
module nor_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/nor_write_timer.sv
module nor_write_timer
  import nor_cmd_pkg::*;
#(
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   cyc_end
);
  localparam int MAX_CLKS = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam logic [CNT_W-1:0] SETUP_LOAD = CNT_W'(SETUP_CLKS - 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CLKS - 1);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = SETUP_LOAD;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_PULSE;
          cnt_d   = PULSE_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PULSE: begin
        if (cnt_zero) begin
          phase_d = PH_HOLD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = SETUP_LOAD;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase   = phase_q;
  assign cyc_end = (phase_q == PH_HOLD);
endmodule

// File: rtl/nor_cmd_rom.sv
module nor_cmd_rom
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  cmd_ctx_t            ctx,
  input  logic [2:0]          step,
  input  logic [ADDR_W-1:0]   target,
  output logic [ADDR_W-1:0]   addr,
  output logic [DATA_W-1:0]   data,
  output logic                last
);
  localparam logic [ADDR_W-1:0] BLOCK_MASK  = {ADDR_W{1'b1}} << BLOCK_LSB;
  localparam logic [ADDR_W-1:0] SECTOR_MASK = {ADDR_W{1'b1}} << SECTOR_LSB;

  logic [ADDR_W-1:0] key_a, key_b, erase_addr;
  logic [7:0]        erase_opc, byte_out;

  always_comb begin
    key_a = ctx.narrow ? ADDR_W'(NARROW_KEY_ADDR_A) : ADDR_W'(WIDE_KEY_ADDR_A);
    key_b = ctx.narrow ? ADDR_W'(NARROW_KEY_ADDR_B) : ADDR_W'(WIDE_KEY_ADDR_B);
    erase_addr = (ctx.op == OP_BLOCK) ? (target & BLOCK_MASK) : (target & SECTOR_MASK);
    unique case ({ctx.narrow, ctx.op == OP_BLOCK})
      2'b01:   erase_opc = BYTE_OPC_HI;
      2'b00:   erase_opc = BYTE_OPC_LO;
      2'b11:   erase_opc = BYTE_OPC_LO;
      default: erase_opc = BYTE_OPC_HI;
    endcase
  end

  always_comb begin
    addr     = key_a;
    byte_out = BYTE_KEY_A;
    if (ctx.op == OP_QUERY) begin
      unique case (step)
        3'd0:    begin addr = key_a; byte_out = BYTE_KEY_A; end
        3'd1:    begin addr = key_b; byte_out = BYTE_KEY_B; end
        default: begin addr = key_a; byte_out = BYTE_QUERY; end
      endcase
    end else begin
      unique case (step)
        3'd0:    begin addr = key_a;      byte_out = BYTE_KEY_A; end
        3'd1:    begin addr = key_b;      byte_out = BYTE_KEY_B; end
        3'd2:    begin addr = key_a;      byte_out = BYTE_ARM;   end
        3'd3:    begin addr = key_a;      byte_out = BYTE_KEY_A; end
        3'd4:    begin addr = key_b;      byte_out = BYTE_KEY_B; end
        default: begin addr = erase_addr; byte_out = erase_opc;  end
      endcase
    end
  end

  generate
    if (DATA_W > 8) begin : g_pad
      assign data = {{(DATA_W-8){1'b0}}, byte_out};
    end else begin : g_nopad
      assign data = byte_out[DATA_W-1:0];
    end
  endgenerate

  assign last = (step == seq_len(ctx.op) - 3'd1);
endmodule

// File: rtl/nor_cmd_sequencer.sv
module nor_cmd_sequencer
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int SETUP_CLKS = 2,
  parameter int PULSE_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_narrow,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_data,
  output logic              flash_ce_n,
  output logic              flash_we_n,
  output logic              busy,
  output logic              done,
  output logic              req_err
);
  logic              rst_n_int;
  logic              run_q, run_d;
  cmd_ctx_t          ctx_q, ctx_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic [2:0]        step_q, step_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              req_bad, accept, timer_start, cyc_end, last;
  phase_e            phase;
  logic [ADDR_W-1:0] rom_addr;
  logic [DATA_W-1:0] rom_data;

  nor_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign req_bad     = (req_op == OP_BAD);
  assign accept      = req_valid && !run_q && !req_bad;
  assign timer_start = accept || (run_q && cyc_end && !last);

  always_comb begin
    run_d  = run_q;
    ctx_d  = ctx_q;
    tgt_d  = tgt_q;
    step_d = step_q;
    if (accept) begin
      run_d      = 1'b1;
      ctx_d.op   = op_e'(req_op);
      ctx_d.narrow = req_narrow;
      tgt_d      = req_addr;
      step_d     = 3'd0;
    end else if (run_q && cyc_end) begin
      if (last) begin
        run_d = 1'b0;
      end else begin
        step_d = step_q + 3'd1;
      end
    end
    done_d = run_q && cyc_end && last;
    err_d  = req_valid && (run_q || req_bad);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      run_q  <= 1'b0;
      ctx_q  <= '{op: OP_BLOCK, narrow: 1'b0};
      tgt_q  <= '0;
      step_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      ctx_q  <= ctx_d;
      tgt_q  <= tgt_d;
      step_q <= step_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  nor_write_timer #(
    .SETUP_CLKS (SETUP_CLKS),
    .PULSE_CLKS (PULSE_CLKS)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start   (timer_start),
    .phase   (phase),
    .cyc_end (cyc_end)
  );

  nor_cmd_rom #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_rom (
    .ctx    (ctx_q),
    .step   (step_q),
    .target (tgt_q),
    .addr   (rom_addr),
    .data   (rom_data),
    .last   (last)
  );

  assign flash_ce_n = (phase == PH_IDLE);
  assign flash_we_n = (phase != PH_PULSE);
  assign flash_addr = flash_ce_n ? '0 : rom_addr;
  assign flash_data = flash_ce_n ? '0 : rom_data;
  assign busy       = run_q;
  assign done       = done_q;
  assign req_err    = err_q;
endmodule

// File: rtl/nor_cmd_sequencer_chk.sv
module nor_cmd_sequencer_chk #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int PULSE_CLKS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [DATA_W-1:0] flash_data,
  input logic              flash_ce_n,
  input logic              flash_we_n,
  input logic              busy,
  input logic              done,
  input logic              req_err
);
  localparam int LOW_W = $clog2(PULSE_CLKS + 2);
  logic [LOW_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (flash_we_n) begin
      low_cnt <= '0;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flash_ce_n |-> (flash_addr == '0 && flash_data == '0));

  a_r7_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> !flash_ce_n);

  a_r7_stable_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> ($stable(flash_addr) && $stable(flash_data)));

  a_r7_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> (!flash_ce_n && $stable(flash_addr) && $stable(flash_data)));

  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> (low_cnt == LOW_W'(PULSE_CLKS)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && flash_ce_n));

  a_r9_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> req_err);

  a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_op == 2'd3) |=> (req_err && !busy));
endmodule

bind nor_cmd_sequencer nor_cmd_sequencer_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .PULSE_CLKS (PULSE_CLKS)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .flash_addr (flash_addr),
  .flash_data (flash_data),
  .flash_ce_n (flash_ce_n),
  .flash_we_n (flash_we_n),
  .busy       (busy),
  .done       (done),
  .req_err    (req_err)
);

// File: tb/test_nor_cmd_sequencer.sv
module test_nor_cmd_sequencer;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int S  = 2;
  localparam int P  = 3;
  localparam int W  = S + P + 1;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic          req_narrow;
  logic [AW-1:0] req_addr;
  logic [AW-1:0] flash_addr;
  logic [DW-1:0] flash_data;
  logic          flash_ce_n, flash_we_n, busy, done, req_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  nor_cmd_sequencer #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CLKS(S), .PULSE_CLKS(P)) i_nor_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_narrow(req_narrow), .req_addr(req_addr), .flash_addr(flash_addr),
    .flash_data(flash_data), .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n),
    .busy(busy), .done(done), .req_err(req_err));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int n_writes(int op);
    return (op == 2) ? 3 : 6;
  endfunction

  function automatic longint exp_data(int op, int nar, int step);
    if (op == 2) return (step == 0) ? 'hAA : (step == 1) ? 'h55 : 'h98;
    case (step)
      0, 3: return 'hAA;
      1, 4: return 'h55;
      2:    return 'h80;
      default: return ((op == 0) == (nar == 1)) ? 'h30 : 'h50;
    endcase
  endfunction

  function automatic longint exp_addr(int op, int nar, longint tgt, int step);
    longint ka = nar ? 'h555 : 'h5555;
    longint kb = nar ? 'h2AA : 'h2AAA;
    if (op == 2) return (step == 1) ? kb : ka;
    case (step)
      0, 2, 3: return ka;
      1, 4:    return kb;
      default: return (op == 0) ? tgt - (tgt % 65536) : tgt - (tgt % 4096);
    endcase
  endfunction

  // Issues one request and checks every clock of the sequence.
  task automatic run_seq(input int op, input int nar, input longint tgt, input bit disturb);
    int n = n_writes(op);
    string dtag, atag;
    req_valid = 1'b1; req_op = op[1:0]; req_narrow = nar[0]; req_addr = tgt[AW-1:0];
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= n * W + 2; c++) begin
      int step = (c - 1) / W;
      int ph   = (c - 1) % W;
      if (c <= n * W) begin
        chk("R7 ce_n/we_n", {flash_ce_n, flash_we_n}, {1'b0, !(ph >= S && ph < S + P)});
        chk("R8 busy/done", {busy, done}, 2'b10);
        if (op == 2) begin dtag = "R6 data"; atag = "R6 addr"; end
        else if (step == 5) begin dtag = nar ? "R4 opcode" : "R3 opcode"; atag = "R5 erase addr"; end
        else begin dtag = "R2 data"; atag = nar ? "R4 addr" : "R3 addr"; end
        if (disturb) begin dtag = {dtag, " R11"}; atag = {atag, " R11"}; end
        chk(dtag, flash_data, exp_data(op, nar, step));
        chk(atag, flash_addr, exp_addr(op, nar, tgt, step));
      end else if (c == n * W + 1) begin
        chk("R8 done pulse", {busy, done, flash_ce_n, flash_we_n}, 4'b0111);
        chk("R1 idle bus", {flash_addr, flash_data}, 0);
      end else begin
        chk("R8 done single", {busy, done, flash_ce_n}, 3'b001);
      end
      if (disturb) begin
        if (c == 2) begin req_narrow = !nar[0]; req_addr = ~tgt[AW-1:0]; end
        if (c == 3) begin req_valid = 1'b1; req_op = 2'd2; end
        if (c == 4) begin chk("R9 err on busy", req_err, 1); req_valid = 1'b0; end
        if (c == 5) chk("R9 err single", req_err, 0);
      end else if (c == 2) begin
        chk("R9 no err on accept", req_err, 0);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    longint addrs[4] = '{'h000000, 'h123456, 'hFFFFFF, 'h010FFF};
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_narrow = 1'b0; req_addr = '0;
    repeat (4) @(negedge clk);
    chk("R1 reset pins", {flash_ce_n, flash_we_n, busy, done, req_err}, 5'b11000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {flash_ce_n, flash_we_n, busy, done, req_err}, 5'b11000);
    chk("R1 bus zero", {flash_addr, flash_data}, 0);

    for (int op = 0; op < 3; op++)
      for (int nar = 0; nar < 2; nar++)
        for (int a = 0; a < 4; a++)
          run_seq(op, nar, addrs[a], 1'b0);

    run_seq(0, 0, 'h3ABCDE, 1'b1);
    run_seq(1, 1, 'h7F1234, 1'b1);

    // R10: invalid code 3 is rejected
    req_valid = 1'b1; req_op = 2'd3; req_narrow = 1'b0; req_addr = 'h123456;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 err", req_err, 1);
    chk("R10 no start", {busy, flash_ce_n, flash_we_n}, 3'b011);
    @(negedge clk);
    chk("R10 still idle", {busy, flash_ce_n, req_err}, 3'b010);
    repeat (W) @(negedge clk);
    chk("R10 no activity", {busy, flash_ce_n, done}, 3'b010);

    run_seq(2, 1, 0, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule